// File: doc/BRIEF.md
# Stack and Break Sequencer

This block carries out the stack half of the control-flow and stack instructions of an 8-bit processor. It owns the 8-bit stack pointer and drives a single-port byte memory, one access per clock. The processor core presents a command together with the current program counter, the current status byte, a data byte and a call target. The sequencer runs the memory accesses the command needs and returns the new program counter, the new status byte and any pulled data byte. The supported commands are: push a byte, push status, pull a byte, pull status, call, return, return from interrupt and software break.

The stack occupies one fixed page (default page 0x01), so a stack address is the page number followed by the pointer. Pushes store first and then move the pointer down. Pulls move the pointer up first and then read. The pointer wraps modulo 256. The memory is expected to have a registered read port: read data appears in the cycle after the address.

A command is taken only when the block is idle. While a sequence runs, the command input is not looked at. The end of each sequence is marked by a one-cycle `done` pulse. At that point the result outputs hold the sequence's outcome, and they keep it until the next sequence finishes.

Top module: `stk_seq`

## Requirements
- R1: Synchronous active-high reset sets the stack pointer to 0xFF, clears `busy`, `done` and `mem_en`, and clears `new_pc`, `new_psw` and `pull_data` to zero.
- R2: Command code 0 (push byte) writes `cmd_data` to address 0x0100 + SP and then decrements SP. `new_pc` and `new_psw` return `cur_pc` and `cur_psw` unchanged.
- R3: Command code 2 (pull byte) increments SP, then reads 0x0100 + SP and returns the byte on `pull_data`.
- R4: Command code 1 (push status) writes `cur_psw` with bit 5 forced to one. Command code 3 (pull status) returns the pulled byte on `new_psw` with bits 5 and 4 forced to one.
- R5: Command code 4 (call) pushes the high byte and then the low byte of `cur_pc` + 1, so the low byte lands at the lower address. It then returns `call_target` on `new_pc`.
- R6: Command code 5 (return) pulls the low byte and then the high byte, and returns that 16-bit value plus one on `new_pc`.
- R7: Command code 6 (return from interrupt) first pulls a status byte and returns it unmodified on `new_psw`. It then pulls the low and high bytes of the return address and returns their value plus one on `new_pc`.
- R8: Command code 7 (break) pushes the high and low bytes of `cur_pc` + 1, then `cur_psw` with bit 4 set. It then reads 0xFFFE (low) and 0xFFFF (high) into `new_pc`, and returns `cur_psw` with bit 2 set and bit 3 cleared on `new_psw`.
- R9: SP wraps modulo 256: a pull at SP 0xFF reads 0x0100, and a push at SP 0x00 leaves SP at 0xFF.
- R10: Counting the accept edge as edge 0, access i of an N-access sequence is on the memory port in the cycle after edge i. `done` is high for exactly the one cycle after edge N+1. N is 1 for codes 0 to 3, 2 for codes 4 and 5, 3 for code 6 and 5 for code 7.
- R11: A command presented while `busy` is high is ignored: it makes no memory access and does not change SP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken only while idle |
| cmd_op | input | 3 | Command code (0 to 7, see requirements) |
| cmd_data | input | 8 | Byte written by push byte |
| cur_pc | input | 16 | Current program counter |
| cur_psw | input | 8 | Current status byte |
| call_target | input | 16 | Destination of a call |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| sp | output | 8 | Stack pointer |
| new_pc | output | 16 | Resulting program counter |
| new_psw | output | 8 | Resulting status byte |
| pull_data | output | 8 | Byte returned by pull byte |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after the address |

## Verification
The accept edge is counted as edge 0. Access i of a command is on the port in the cycle after edge i, and the results and the `done` pulse appear in the cycle after edge N+1. The bench drives commands on falling edges and samples on every falling edge that follows. It requires `mem_en` high for exactly the first N of those samples and `done` high only at sample N+1, and it reads the result ports and the stack memory model only after that sample. For the busy-time test, the stray command is held across the edges where the sequencer is running and is dropped before the pulse. The bench then checks SP and the memory bytes it could have overwritten.

// File: rtl/stk_seq_pkg.sv
`timescale 1ns/1ps
package stk_seq_pkg;
  localparam int DW    = 8;
  localparam int AW    = 16;
  localparam int IDX_W = 3;

  typedef enum logic [2:0] {
    OP_PUSH_BYTE = 3'd0,
    OP_PUSH_PSW  = 3'd1,
    OP_PULL_BYTE = 3'd2,
    OP_PULL_PSW  = 3'd3,
    OP_CALL      = 3'd4,
    OP_RETURN    = 3'd5,
    OP_RETI      = 3'd6,
    OP_BREAK     = 3'd7
  } op_t;

  // kind of memory access performed by one step
  typedef enum logic [1:0] {AC_PUSH, AC_PULL, AC_VEC_LO, AC_VEC_HI} acc_t;
  // source of the byte written by a push step
  typedef enum logic [2:0] {WS_DATA, WS_PSW_SW, WS_PSW_BRK, WS_RET_HI, WS_RET_LO} wsrc_t;
  // where the byte returned by a read step goes
  typedef enum logic [1:0] {RD_NONE, RD_LO, RD_PSW, RD_FINAL} rdst_t;

  typedef struct packed {
    acc_t  acc;
    wsrc_t src;
    rdst_t dst;
    logic  last;
  } step_t;

  localparam logic [DW-1:0] MASK_RSV = 8'h20;
  localparam logic [DW-1:0] MASK_BRK = 8'h10;
  localparam logic [DW-1:0] MASK_DEC = 8'h08;
  localparam logic [DW-1:0] MASK_IRQ = 8'h04;

  function automatic step_t mk_step(acc_t a, wsrc_t s, rdst_t d, logic l);
    step_t r;
    r.acc  = a;
    r.src  = s;
    r.dst  = d;
    r.last = l;
    return r;
  endfunction
endpackage

// File: rtl/stk_seq_decode.sv
`timescale 1ns/1ps
module stk_seq_decode
  import stk_seq_pkg::*;
(
  input  op_t              op,
  input  logic [IDX_W-1:0] idx,
  output step_t            step
);
  always_comb begin
    step = mk_step(AC_PULL, WS_DATA, RD_NONE, 1'b1);
    unique case (op)
      OP_PUSH_BYTE: step = mk_step(AC_PUSH, WS_DATA,   RD_NONE,  1'b1);
      OP_PUSH_PSW:  step = mk_step(AC_PUSH, WS_PSW_SW, RD_NONE,  1'b1);
      OP_PULL_BYTE: step = mk_step(AC_PULL, WS_DATA,   RD_FINAL, 1'b1);
      OP_PULL_PSW:  step = mk_step(AC_PULL, WS_DATA,   RD_FINAL, 1'b1);
      OP_CALL: begin
        if (idx == 3'd0) step = mk_step(AC_PUSH, WS_RET_HI, RD_NONE, 1'b0);
        else             step = mk_step(AC_PUSH, WS_RET_LO, RD_NONE, 1'b1);
      end
      OP_RETURN: begin
        if (idx == 3'd0) step = mk_step(AC_PULL, WS_DATA, RD_LO,    1'b0);
        else             step = mk_step(AC_PULL, WS_DATA, RD_FINAL, 1'b1);
      end
      OP_RETI: begin
        case (idx)
          3'd0:    step = mk_step(AC_PULL, WS_DATA, RD_PSW,   1'b0);
          3'd1:    step = mk_step(AC_PULL, WS_DATA, RD_LO,    1'b0);
          default: step = mk_step(AC_PULL, WS_DATA, RD_FINAL, 1'b1);
        endcase
      end
      OP_BREAK: begin
        case (idx)
          3'd0:    step = mk_step(AC_PUSH,   WS_RET_HI,  RD_NONE,  1'b0);
          3'd1:    step = mk_step(AC_PUSH,   WS_RET_LO,  RD_NONE,  1'b0);
          3'd2:    step = mk_step(AC_PUSH,   WS_PSW_BRK, RD_NONE,  1'b0);
          3'd3:    step = mk_step(AC_VEC_LO, WS_DATA,    RD_LO,    1'b0);
          default: step = mk_step(AC_VEC_HI, WS_DATA,    RD_FINAL, 1'b1);
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/stk_seq_ptr.sv
`timescale 1ns/1ps
module stk_seq_ptr
  import stk_seq_pkg::*;
#(
  parameter logic [DW-1:0] STACK_PAGE = 8'h01,
  parameter logic [AW-1:0] BRK_VEC    = 16'hFFFE,
  parameter logic [DW-1:0] SP_INIT    = 8'hFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  acc_t          acc,
  output logic [DW-1:0] sp,
  output logic [AW-1:0] addr
);
  logic [DW-1:0] sp_q;
  logic [DW-1:0] sp_up;
  logic [DW-1:0] sp_dn;

  assign sp_up = sp_q + 8'd1;
  assign sp_dn = sp_q - 8'd1;
  assign sp    = sp_q;

  // push uses the pointer as it stands, pull uses the incremented one
  always_comb begin
    unique case (acc)
      AC_PUSH:   addr = {STACK_PAGE, sp_q};
      AC_PULL:   addr = {STACK_PAGE, sp_up};
      AC_VEC_LO: addr = BRK_VEC;
      default:   addr = BRK_VEC + 16'd1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q <= SP_INIT;
    end else if (adv) begin
      if (acc == AC_PUSH)      sp_q <= sp_dn;
      else if (acc == AC_PULL) sp_q <= sp_up;
    end
  end
endmodule

// File: rtl/stk_seq_result.sv
`timescale 1ns/1ps
module stk_seq_result
  import stk_seq_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  op_t           op_q,
  input  logic [AW-1:0] pc_q,
  input  logic [DW-1:0] psw_q,
  input  logic [AW-1:0] tgt_q,
  input  rdst_t         pend_dst,
  input  logic [DW-1:0] rdata,
  input  logic          finish,
  output logic [AW-1:0] new_pc,
  output logic [DW-1:0] new_psw,
  output logic [DW-1:0] pull_data
);
  logic [DW-1:0] lo_q;
  logic [DW-1:0] stk_psw_q;
  logic [AW-1:0] popped;

  assign popped = {rdata, lo_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q      <= '0;
      stk_psw_q <= '0;
      new_pc    <= '0;
      new_psw   <= '0;
      pull_data <= '0;
    end else begin
      if (pend_dst == RD_LO)  lo_q      <= rdata;
      if (pend_dst == RD_PSW) stk_psw_q <= rdata;
      if (finish) begin
        new_pc  <= pc_q;
        new_psw <= psw_q;
        unique case (op_q)
          OP_PULL_BYTE: pull_data <= rdata;
          OP_PULL_PSW:  new_psw   <= rdata | MASK_RSV | MASK_BRK;
          OP_CALL:      new_pc    <= tgt_q;
          OP_RETURN:    new_pc    <= popped + 16'd1;
          OP_RETI: begin
            new_pc  <= popped + 16'd1;
            new_psw <= stk_psw_q;
          end
          OP_BREAK: begin
            new_pc  <= popped;
            new_psw <= (psw_q | MASK_IRQ) & ~MASK_DEC;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/stk_seq.sv
`timescale 1ns/1ps
module stk_seq
  import stk_seq_pkg::*;
#(
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] BRK_VEC    = 16'hFFFE,
  parameter logic [7:0]  SP_INIT    = 8'hFF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_op,
  input  logic [7:0]  cmd_data,
  input  logic [15:0] cur_pc,
  input  logic [7:0]  cur_psw,
  input  logic [15:0] call_target,
  output logic        busy,
  output logic        done,
  output logic [7:0]  sp,
  output logic [15:0] new_pc,
  output logic [7:0]  new_psw,
  output logic [7:0]  pull_data,
  output logic        mem_en,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_WAIT, S_FIN} st_t;

  st_t              st_q;
  op_t              op_q;
  logic [IDX_W-1:0] idx_q;
  logic [AW-1:0]    pc_q;
  logic [AW-1:0]    tgt_q;
  logic [DW-1:0]    psw_q;
  logic [DW-1:0]    data_q;
  rdst_t            cur_dst_q;
  rdst_t            pend_dst_q;
  logic             done_q;
  logic             en_q;
  logic             we_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;

  logic             accept;
  logic             launch;
  op_t              op_v;
  logic [IDX_W-1:0] idx_v;
  logic [AW-1:0]    pc_v;
  logic [AW-1:0]    ret_v;
  logic [DW-1:0]    psw_v;
  logic [DW-1:0]    data_v;
  logic [DW-1:0]    wdata;
  logic [AW-1:0]    step_addr;
  step_t            step;

  assign accept = (st_q == S_IDLE) && cmd_valid;
  assign launch = accept || (st_q == S_RUN);
  assign op_v   = accept ? op_t'(cmd_op) : op_q;
  assign idx_v  = accept ? '0 : idx_q;
  assign pc_v   = accept ? cur_pc : pc_q;
  assign psw_v  = accept ? cur_psw : psw_q;
  assign data_v = accept ? cmd_data : data_q;
  assign ret_v  = pc_v + 16'd1;

  stk_seq_decode u_decode (
    .op   (op_v),
    .idx  (idx_v),
    .step (step)
  );

  stk_seq_ptr #(
    .STACK_PAGE (STACK_PAGE),
    .BRK_VEC    (BRK_VEC),
    .SP_INIT    (SP_INIT)
  ) u_ptr (
    .clk  (clk),
    .rst  (rst),
    .adv  (launch),
    .acc  (step.acc),
    .sp   (sp),
    .addr (step_addr)
  );

  always_comb begin
    unique case (step.src)
      WS_DATA:    wdata = data_v;
      WS_PSW_SW:  wdata = psw_v | MASK_RSV;
      WS_PSW_BRK: wdata = psw_v | MASK_BRK;
      WS_RET_HI:  wdata = ret_v[AW-1:DW];
      WS_RET_LO:  wdata = ret_v[DW-1:0];
      default:    wdata = data_v;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= S_IDLE;
      op_q       <= OP_PUSH_BYTE;
      idx_q      <= '0;
      pc_q       <= '0;
      tgt_q      <= '0;
      psw_q      <= '0;
      data_q     <= '0;
      cur_dst_q  <= RD_NONE;
      pend_dst_q <= RD_NONE;
      done_q     <= 1'b0;
      en_q       <= 1'b0;
      we_q       <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
    end else begin
      done_q     <= (st_q == S_FIN);
      en_q       <= launch;
      we_q       <= launch && (step.acc == AC_PUSH);
      cur_dst_q  <= (launch && step.acc != AC_PUSH) ? step.dst : RD_NONE;
      pend_dst_q <= cur_dst_q;
      if (launch) begin
        addr_q  <= step_addr;
        wdata_q <= wdata;
      end
      if (accept) begin
        op_q   <= op_t'(cmd_op);
        pc_q   <= cur_pc;
        tgt_q  <= call_target;
        psw_q  <= cur_psw;
        data_q <= cmd_data;
      end
      unique case (st_q)
        S_IDLE: if (accept) begin
          idx_q <= 3'd1;
          st_q  <= step.last ? S_WAIT : S_RUN;
        end
        S_RUN: begin
          idx_q <= idx_q + 3'd1;
          if (step.last) st_q <= S_WAIT;
        end
        S_WAIT: st_q <= S_FIN;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  stk_seq_result u_result (
    .clk       (clk),
    .rst       (rst),
    .op_q      (op_q),
    .pc_q      (pc_q),
    .psw_q     (psw_q),
    .tgt_q     (tgt_q),
    .pend_dst  (pend_dst_q),
    .rdata     (mem_rdata),
    .finish    (st_q == S_FIN),
    .new_pc    (new_pc),
    .new_psw   (new_psw),
    .pull_data (pull_data)
  );

  assign busy      = (st_q != S_IDLE);
  assign done      = done_q;
  assign mem_en    = en_q;
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
endmodule

// File: rtl/stk_seq_chk.sv
`timescale 1ns/1ps
module stk_seq_chk #(
  parameter logic [7:0] STACK_PAGE = 8'h01,
  parameter logic [7:0] SP_INIT    = 8'hFF
) (
  input logic        clk,
  input logic        rst,
  input logic        cmd_valid,
  input logic        busy,
  input logic        done,
  input logic [7:0]  sp,
  input logic [7:0]  new_psw,
  input logic        mem_en,
  input logic        mem_we,
  input logic [15:0] mem_addr,
  input logic [2:0]  op_q
);
  // R1: reset leaves the pointer at its initial value and the block idle
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (sp == SP_INIT) && !busy && !done);

  // R2: a write lands one above the already decremented pointer
  assert_push_addr_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_we) |-> (mem_addr == {STACK_PAGE, sp + 8'd1}));

  // R3: a stack read uses the already incremented pointer
  assert_pull_addr_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_en && !mem_we && mem_addr[15:8] == STACK_PAGE) |-> (mem_addr[7:0] == sp));

  // R8: break finishes with interrupt bit set and decimal bit clear
  assert_break_flags_R8: assert property (@(posedge clk) disable iff (rst)
    (done && op_q == 3'd7) |-> (new_psw[2] && !new_psw[3]));

  // R10: completion is a single pulse seen only once the port is quiet
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !mem_en));

  // R11: work starts only from a strobe seen while idle
  assert_start_cause_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cmd_valid));
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!busy && !cmd_valid) |=> (!busy && !mem_en));
endmodule

bind stk_seq stk_seq_chk #(
  .STACK_PAGE (STACK_PAGE),
  .SP_INIT    (SP_INIT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .busy      (busy),
  .done      (done),
  .sp        (sp),
  .new_psw   (new_psw),
  .mem_en    (mem_en),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .op_q      (op_q)
);

// File: tb/stk_seq_bench.sv
`timescale 1ns/1ps
module stk_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [7:0]  cmd_data = '0;
  logic [15:0] cur_pc = '0;
  logic [7:0]  cur_psw = '0;
  logic [15:0] call_target = '0;
  logic        busy, done, mem_en, mem_we;
  logic [7:0]  sp, new_psw, pull_data, mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic [15:0] new_pc, mem_addr;

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  localparam logic [7:0] VEC_LO = 8'h12;
  localparam logic [7:0] VEC_HI = 8'hC0;

  always #2 clk = ~clk;

  stk_seq u_stk_seq (
    .clk (clk), .rst (rst), .cmd_valid (cmd_valid), .cmd_op (cmd_op),
    .cmd_data (cmd_data), .cur_pc (cur_pc), .cur_psw (cur_psw),
    .call_target (call_target), .busy (busy), .done (done), .sp (sp),
    .new_pc (new_pc), .new_psw (new_psw), .pull_data (pull_data),
    .mem_en (mem_en), .mem_we (mem_we), .mem_addr (mem_addr),
    .mem_wdata (mem_wdata), .mem_rdata (mem_rdata)
  );

  // stack page plus the two break vector bytes, registered read
  logic [7:0] stack_mem [256];
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we && mem_addr[15:8] == 8'h01) stack_mem[mem_addr[7:0]] <= mem_wdata;
      if (mem_addr[15:8] == 8'h01) mem_rdata <= stack_mem[mem_addr[7:0]];
      else if (mem_addr == 16'hFFFE) mem_rdata <= VEC_LO;
      else if (mem_addr == 16'hFFFF) mem_rdata <= VEC_HI;
      else mem_rdata <= 8'h00;
    end
  end

  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] pc;
    logic [7:0]  psw;
    logic [7:0]  dat;
    logic [15:0] tgt;
    logic [7:0]  e_sp;
    logic [15:0] e_pc;
    logic [7:0]  e_psw;
    logic [7:0]  e_pull;
    logic        m_chk;
    logic [7:0]  m_addr;
    logic [7:0]  m_val;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{3'd0, 16'h1000, 8'h00, 8'hA5, 16'h0000, 8'hFE, 16'h1000, 8'h00, 8'h00, 1'b1, 8'hFF, 8'hA5},
    '{3'd1, 16'h1000, 8'hC3, 8'h00, 16'h0000, 8'hFD, 16'h1000, 8'hC3, 8'h00, 1'b1, 8'hFE, 8'hE3},
    '{3'd3, 16'h1000, 8'h00, 8'h00, 16'h0000, 8'hFE, 16'h1000, 8'hF3, 8'h00, 1'b0, 8'h00, 8'h00},
    '{3'd2, 16'h1000, 8'h00, 8'h00, 16'h0000, 8'hFF, 16'h1000, 8'h00, 8'hA5, 1'b0, 8'h00, 8'h00},
    '{3'd4, 16'h2345, 8'h01, 8'h00, 16'h8000, 8'hFD, 16'h8000, 8'h01, 8'hA5, 1'b1, 8'hFE, 8'h46},
    '{3'd5, 16'h8003, 8'h01, 8'h00, 16'h0000, 8'hFF, 16'h2347, 8'h01, 8'hA5, 1'b1, 8'hFF, 8'h23},
    '{3'd7, 16'h3000, 8'h09, 8'h00, 16'h0000, 8'hFC, 16'hC012, 8'h05, 8'hA5, 1'b1, 8'hFD, 8'h19},
    '{3'd6, 16'hC020, 8'h00, 8'h00, 16'h0000, 8'hFF, 16'h3002, 8'h19, 8'hA5, 1'b1, 8'hFE, 8'h01},
    '{3'd2, 16'h4000, 8'h80, 8'h00, 16'h0000, 8'h00, 16'h4000, 8'h80, 8'h00, 1'b0, 8'h00, 8'h00},
    '{3'd0, 16'h4000, 8'h80, 8'h77, 16'h0000, 8'hFF, 16'h4000, 8'h80, 8'h00, 1'b1, 8'h00, 8'h77},
    '{3'd2, 16'h4000, 8'h80, 8'h00, 16'h0000, 8'h00, 16'h4000, 8'h80, 8'h77, 1'b0, 8'h00, 8'h00},
    '{3'd1, 16'h4000, 8'h00, 8'h00, 16'h0000, 8'hFF, 16'h4000, 8'h00, 8'h77, 1'b1, 8'h00, 8'h20},
    '{3'd3, 16'h4000, 8'h00, 8'h00, 16'h0000, 8'h00, 16'h4000, 8'h30, 8'h77, 1'b0, 8'h00, 8'h00}
  };

  function automatic int nacc_of(input logic [2:0] op);
    case (op)
      3'd4, 3'd5: return 2;
      3'd6:       return 3;
      3'd7:       return 5;
      default:    return 1;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0:       return "R2";
      3'd2:       return "R3";
      3'd1, 3'd3: return "R4";
      3'd4:       return "R5";
      3'd5:       return "R6";
      3'd6:       return "R7";
      default:    return "R8";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drives one command and checks the access window and done latency (R10)
  task automatic run_cmd(input logic [2:0] op, input logic [15:0] pc,
                         input logic [7:0] psw, input logic [7:0] dat,
                         input logic [15:0] tgt, input bit stray);
    int n;
    logic ok_acc;
    logic ok_done;
    n = nacc_of(op);
    ok_acc = 1'b1;
    ok_done = 1'b1;
    @(negedge clk);
    cmd_op = op; cur_pc = pc; cur_psw = psw; cmd_data = dat; call_target = tgt;
    cmd_valid = 1'b1;
    for (int k = 0; k <= n + 1; k++) begin
      @(negedge clk);
      if (k == 0) begin
        if (stray) begin
          cmd_op = 3'd0;
          cmd_data = 8'hEE;
        end else begin
          cmd_valid = 1'b0;
        end
      end
      if (stray && k == n) cmd_valid = 1'b0;
      if (mem_en !== 1'(k < n)) ok_acc = 1'b0;
      if (done !== 1'(k == n + 1)) ok_done = 1'b0;
    end
    check("R10", "access window", 16'(ok_acc), 16'd1);
    check("R10", "done latency", 16'(ok_done), 16'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) stack_mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "sp", 16'(sp), 16'h00FF);
    check("R1", "busy/done/mem_en", 16'({busy, done, mem_en}), 16'd0);
    check("R1", "new_pc", new_pc, 16'h0000);
    check("R1", "new_psw/pull", {new_psw, pull_data}, 16'h0000);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      string req;
      req = (v >= 8) ? "R9" : req_of(TBL[v].op);
      run_cmd(TBL[v].op, TBL[v].pc, TBL[v].psw, TBL[v].dat, TBL[v].tgt, 1'b0);
      check(req, "sp", 16'(sp), 16'(TBL[v].e_sp));
      check(req, "new_pc", new_pc, TBL[v].e_pc);
      check(req, "new_psw", 16'(new_psw), 16'(TBL[v].e_psw));
      check(req, "pull_data", 16'(pull_data), 16'(TBL[v].e_pull));
      if (TBL[v].m_chk)
        check(req, "stack byte", 16'(stack_mem[TBL[v].m_addr]), 16'(TBL[v].m_val));
    end

    // R11: push of 0xEE held high during a call must be dropped
    run_cmd(3'd4, 16'h5000, 8'h00, 8'h00, 16'h9000, 1'b1);
    check("R11", "sp after call", 16'(sp), 16'h00FE);
    check("R11", "new_pc", new_pc, 16'h9000);
    check("R11", "byte below call frame", 16'(stack_mem[8'hFD]), 16'h0019);
    check("R11", "call high byte", 16'(stack_mem[8'h00]), 16'h0050);
    check("R11", "call low byte", 16'(stack_mem[8'hFF]), 16'h0001);
    check("R11", "stale byte at FE", 16'(stack_mem[8'hFE]), 16'h0001);
    @(negedge clk);
    check("R11", "idle after done", 16'({busy, mem_en}), 16'd0);

    // R1: reset after activity restores the initial state
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "sp after rerun reset", 16'(sp), 16'h00FF);
    check("R1", "outputs after rerun reset", new_pc, 16'h0000);
    rst = 1'b0;
    @(negedge clk);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule